// File: doc/BRIEF.md
# Command/Indicate Octet Port

This block is the pin-side end of a signalling channel on a time-division serial bus. In every frame one octet travels in each direction during a slot that the bus timing marks with a strobe. The downstream octet is shifted in one bit per bit-clock pulse. Once it is complete, its top bit chooses which of the two line channels takes the new output pin levels. The upstream octet is built from a snapshot of both channels' input pins plus two handshake bits supplied by a separate monitor controller. It is shifted out most significant bit first.

The three bidirectional signalling pins of each channel have a per-pin direction input. A pin set as an output takes its level from the downstream octet. A pin set as an input keeps its latch unchanged. Only the first bidirectional pin of each channel can be reported upstream, and only while it is set as an input. The two handshake bits received downstream are handed to the monitor controller together with a one-cycle strobe. Choosing which slot of the frame carries the octet, and the monitor protocol itself, are handled elsewhere.

Top module: `cip_top`

## Requirements
- R1: While reset is low and after its release, all output latches (so_*, sb_*) are 0, mon_mr_o and mon_mx_o are 1, mon_valid_o is 0, up_en_o is 0 and up_bit_o is 1.
- R2: Upstream bits go out most significant first, one per accepted bit pulse. Bits 7 down to 0 are SI1 of A, SI2 of A, SB1 of A, SI1 of B, SI2 of B, SB1 of B, mon_mr_i, mon_mx_i. Here SIn is si_*_i[n-1] and SBn is sb_*_i[n-1]. Outside the active slot up_bit_o is 1.
- R3: The SB1 position of a channel carries the pin level when sb_oe_*_i[0] is 0 (input). It carries 1 when sb_oe_*_i[0] is 1 (output). SB2 and SB3 input levels never reach the upstream octet.
- R4: All upstream pin and handshake values are captured at the clock edge where slot_i rises. Changes to them later in the slot do not alter the octet.
- R5: Downstream bits 7 down to 0 are channel select, SO2, SO1, SB3, SB2, SB1, MR, MX. Select 0 updates only channel A and 1 updates only channel B, with so_*_o[1] = SO2 and so_*_o[0] = SO1. The other channel's outputs are unchanged.
- R6: A downstream SBn bit reaches sb_*_o[n-1] of the selected channel only if sb_oe_*_i[n-1] is 1. Otherwise that latch keeps its value.
- R7: Output latches change only after the eighth bit of a slot. A slot that ends after fewer than eight bits changes no output and raises no strobe.
- R8: Each complete downstream octet raises mon_valid_o for exactly one cycle. In that same cycle mon_mr_o and mon_mx_o take bits 1 and 0, and they hold those values until the next complete octet.
- R9: up_en_o is high only while slot_i is high, from the cycle after its rising edge until eight bits have been accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fsc_i | input | 1 | Frame sync; clears the bit position |
| slot_i | input | 1 | High for the duration of the octet slot; rising edge starts it |
| bit_en_i | input | 1 | One-cycle bit clock pulse; needs slot_i high for at least one cycle before it |
| dn_bit_i | input | 1 | Downstream serial data |
| up_bit_o | output | 1 | Upstream serial data |
| up_en_o | output | 1 | Upstream drive enable |
| si_a_i | input | 2 | Channel A input pins SI2..SI1 |
| sb_a_i | input | 3 | Channel A bidirectional pin levels SB3..SB1 |
| sb_oe_a_i | input | 3 | Channel A bidirectional direction, 1 = output |
| so_a_o | output | 2 | Channel A output latches SO2..SO1 |
| sb_a_o | output | 3 | Channel A bidirectional output latches SB3..SB1 |
| si_b_i | input | 2 | Channel B input pins SI2..SI1 |
| sb_b_i | input | 3 | Channel B bidirectional pin levels SB3..SB1 |
| sb_oe_b_i | input | 3 | Channel B bidirectional direction, 1 = output |
| so_b_o | output | 2 | Channel B output latches SO2..SO1 |
| sb_b_o | output | 3 | Channel B bidirectional output latches SB3..SB1 |
| mon_mr_i | input | 1 | Upstream MR bit from the monitor controller |
| mon_mx_i | input | 1 | Upstream MX bit from the monitor controller |
| mon_valid_o | output | 1 | Strobe: a complete downstream octet arrived |
| mon_mr_o | output | 1 | Received MR bit |
| mon_mx_o | output | 1 | Received MX bit |

## Verification
The hardest situations to reach from the ports are an input pin that changes after the upstream snapshot was taken, and a slot cut short before its eighth bit. The bench toggles every input pin at random after the third bit of each slot and compares the octet against the values present when the slot began. It also ends roughly one slot in eight after a random number of bits below eight, then checks that no latch moved and no strobe appeared. Random per-pin direction settings together with random channel select show that a latch follows downstream data only when its pin is an output on the addressed channel.

// File: rtl/cip_pkg.sv
package cip_pkg;
  localparam int OCT_W = 8;
  localparam int CNT_W = $clog2(OCT_W) + 1;
  localparam int IDX_W = $clog2(OCT_W);
  localparam int SB_W  = 3;
  localparam int SI_W  = 2;
  localparam int SO_W  = 2;

  typedef struct packed {
    logic sel_b;
    logic so2;
    logic so1;
    logic sb3;
    logic sb2;
    logic sb1;
    logic mr;
    logic mx;
  } dn_oct_t;

  typedef struct packed {
    logic si1_a;
    logic si2_a;
    logic sb1_a;
    logic si1_b;
    logic si2_b;
    logic sb1_b;
    logic mr;
    logic mx;
  } up_oct_t;
endpackage

// File: rtl/cip_timing.sv
module cip_timing
  import cip_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fsc_i,
  input  logic             slot_i,
  input  logic             bit_en_i,
  output logic             slot_start_o,
  output logic             active_o,
  output logic             bit_stb_o,
  output logic             last_bit_o,
  output logic [CNT_W-1:0] bit_idx_o
);
  logic             slot_q;
  logic [CNT_W-1:0] idx_q;

  assign slot_start_o = slot_i & ~slot_q;
  assign active_o     = slot_i & slot_q & (idx_q < CNT_W'(OCT_W));
  assign bit_stb_o    = active_o & bit_en_i;
  assign last_bit_o   = bit_stb_o & (idx_q == CNT_W'(OCT_W - 1));
  assign bit_idx_o    = idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      slot_q <= slot_i;
      if (fsc_i || slot_start_o) idx_q <= '0;
      else if (bit_stb_o)        idx_q <= idx_q + 1'b1;
    end
  end
endmodule

// File: rtl/cip_rx.sv
module cip_rx
  import cip_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    slot_start_i,
  input  logic    bit_stb_i,
  input  logic    last_bit_i,
  input  logic    dn_bit_i,
  output dn_oct_t oct_o,
  output logic    valid_o
);
  logic [OCT_W-2:0] shift_q;
  dn_oct_t          oct_q;
  logic             valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_q <= '0;
      oct_q   <= '1;
      valid_q <= 1'b0;
    end else begin
      valid_q <= last_bit_i;
      if (slot_start_i)   shift_q <= '0;
      else if (bit_stb_i) shift_q <= {shift_q[OCT_W-3:0], dn_bit_i};
      if (last_bit_i)     oct_q   <= dn_oct_t'({shift_q, dn_bit_i});
    end
  end

  assign oct_o   = oct_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/cip_tx.sv
module cip_tx
  import cip_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             slot_start_i,
  input  logic             active_i,
  input  logic [CNT_W-1:0] bit_idx_i,
  input  logic [SI_W-1:0]  si_a_i,
  input  logic             sb1_a_i,
  input  logic             sb1_oe_a_i,
  input  logic [SI_W-1:0]  si_b_i,
  input  logic             sb1_b_i,
  input  logic             sb1_oe_b_i,
  input  logic             mr_i,
  input  logic             mx_i,
  output logic             up_bit_o,
  output logic             up_en_o
);
  up_oct_t          snap_q;
  up_oct_t          snap_d;
  logic [IDX_W-1:0] pos;

  always_comb begin
    snap_d.si1_a = si_a_i[0];
    snap_d.si2_a = si_a_i[1];
    snap_d.sb1_a = sb1_oe_a_i | sb1_a_i;  // output-configured pin reads as 1
    snap_d.si1_b = si_b_i[0];
    snap_d.si2_b = si_b_i[1];
    snap_d.sb1_b = sb1_oe_b_i | sb1_b_i;
    snap_d.mr    = mr_i;
    snap_d.mx    = mx_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           snap_q <= '1;
    else if (slot_start_i) snap_q <= snap_d;
  end

  assign pos      = IDX_W'(OCT_W - 1) - bit_idx_i[IDX_W-1:0];
  assign up_bit_o = active_i ? snap_q[pos] : 1'b1;
  assign up_en_o  = active_i;
endmodule

// File: rtl/cip_chan_latch.sv
module cip_chan_latch
  import cip_pkg::*;
#(
  parameter logic CH_SEL = 1'b0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  dn_oct_t         oct_i,
  input  logic [SB_W-1:0] sb_oe_i,
  output logic [SO_W-1:0] so_o,
  output logic [SB_W-1:0] sb_o
);
  logic            upd;
  logic [SB_W-1:0] sb_new;

  assign upd    = valid_i & (oct_i.sel_b == CH_SEL);
  assign sb_new = {oct_i.sb3, oct_i.sb2, oct_i.sb1};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      so_o <= '0;
      sb_o <= '0;
    end else if (upd) begin
      so_o <= {oct_i.so2, oct_i.so1};
      sb_o <= (sb_o & ~sb_oe_i) | (sb_new & sb_oe_i);
    end
  end
endmodule

// File: rtl/cip_top.sv
module cip_top
  import cip_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            fsc_i,
  input  logic            slot_i,
  input  logic            bit_en_i,
  input  logic            dn_bit_i,
  output logic            up_bit_o,
  output logic            up_en_o,
  input  logic [SI_W-1:0] si_a_i,
  input  logic [SB_W-1:0] sb_a_i,
  input  logic [SB_W-1:0] sb_oe_a_i,
  output logic [SO_W-1:0] so_a_o,
  output logic [SB_W-1:0] sb_a_o,
  input  logic [SI_W-1:0] si_b_i,
  input  logic [SB_W-1:0] sb_b_i,
  input  logic [SB_W-1:0] sb_oe_b_i,
  output logic [SO_W-1:0] so_b_o,
  output logic [SB_W-1:0] sb_b_o,
  input  logic            mon_mr_i,
  input  logic            mon_mx_i,
  output logic            mon_valid_o,
  output logic            mon_mr_o,
  output logic            mon_mx_o
);
  localparam int N_CH = 2;

  logic             slot_start, active, bit_stb, last_bit;
  logic [CNT_W-1:0] bit_idx;
  dn_oct_t          dn_oct;
  logic             dn_valid;

  logic [SB_W-1:0]  oe_w [N_CH];
  logic [SO_W-1:0]  so_w [N_CH];
  logic [SB_W-1:0]  sb_w [N_CH];

  cip_timing u_timing (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fsc_i        (fsc_i),
    .slot_i       (slot_i),
    .bit_en_i     (bit_en_i),
    .slot_start_o (slot_start),
    .active_o     (active),
    .bit_stb_o    (bit_stb),
    .last_bit_o   (last_bit),
    .bit_idx_o    (bit_idx)
  );

  cip_rx u_rx (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .slot_start_i (slot_start),
    .bit_stb_i    (bit_stb),
    .last_bit_i   (last_bit),
    .dn_bit_i     (dn_bit_i),
    .oct_o        (dn_oct),
    .valid_o      (dn_valid)
  );

  cip_tx u_tx (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .slot_start_i (slot_start),
    .active_i     (active),
    .bit_idx_i    (bit_idx),
    .si_a_i       (si_a_i),
    .sb1_a_i      (sb_a_i[0]),
    .sb1_oe_a_i   (sb_oe_a_i[0]),
    .si_b_i       (si_b_i),
    .sb1_b_i      (sb_b_i[0]),
    .sb1_oe_b_i   (sb_oe_b_i[0]),
    .mr_i         (mon_mr_i),
    .mx_i         (mon_mx_i),
    .up_bit_o     (up_bit_o),
    .up_en_o      (up_en_o)
  );

  assign oe_w[0] = sb_oe_a_i;
  assign oe_w[1] = sb_oe_b_i;

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    cip_chan_latch #(.CH_SEL(ch[0])) u_latch (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .valid_i (dn_valid),
      .oct_i   (dn_oct),
      .sb_oe_i (oe_w[ch]),
      .so_o    (so_w[ch]),
      .sb_o    (sb_w[ch])
    );
  end

  assign so_a_o      = so_w[0];
  assign sb_a_o      = sb_w[0];
  assign so_b_o      = so_w[1];
  assign sb_b_o      = sb_w[1];
  assign mon_valid_o = dn_valid;
  assign mon_mr_o    = dn_oct.mr;
  assign mon_mx_o    = dn_oct.mx;
endmodule

// File: rtl/cip_checker.sv
module cip_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       slot_i,
  input logic       up_bit_o,
  input logic       up_en_o,
  input logic [2:0] sb_oe_a_i,
  input logic [2:0] sb_oe_b_i,
  input logic [1:0] so_a_o,
  input logic [2:0] sb_a_o,
  input logic [1:0] so_b_o,
  input logic [2:0] sb_b_o,
  input logic       mon_valid_o,
  input logic       mon_mr_o,
  input logic       mon_mx_o
);
  // R7
  a_latch_after_octet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable({so_a_o, sb_a_o}) |-> $past(mon_valid_o));
  // R7
  b_latch_after_octet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable({so_b_o, sb_b_o}) |-> $past(mon_valid_o));
  // R6
  a_sb_input_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((sb_a_o ^ $past(sb_a_o)) & ~$past(sb_oe_a_i)) == 3'b000);
  // R6
  b_sb_input_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((sb_b_o ^ $past(sb_b_o)) & ~$past(sb_oe_b_i)) == 3'b000);
  // R8
  mon_strobe_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mon_valid_o |=> !mon_valid_o);
  // R8
  mon_bits_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable({mon_mr_o, mon_mx_o}) |-> mon_valid_o);
  // R9
  up_en_in_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    up_en_o |-> slot_i);
  // R2
  up_idle_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !up_en_o |-> up_bit_o);
endmodule

bind cip_top cip_checker u_cip_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .slot_i      (slot_i),
  .up_bit_o    (up_bit_o),
  .up_en_o     (up_en_o),
  .sb_oe_a_i   (sb_oe_a_i),
  .sb_oe_b_i   (sb_oe_b_i),
  .so_a_o      (so_a_o),
  .sb_a_o      (sb_a_o),
  .so_b_o      (so_b_o),
  .sb_b_o      (sb_b_o),
  .mon_valid_o (mon_valid_o),
  .mon_mr_o    (mon_mr_o),
  .mon_mx_o    (mon_mx_o)
);

// File: tb/cip_top_bench.sv
module cip_top_bench;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic fsc_i = 1'b0, slot_i = 1'b0, bit_en_i = 1'b0, dn_bit_i = 1'b0;
  logic up_bit_o, up_en_o;
  logic [1:0] si_a_i = '0, si_b_i = '0;
  logic [2:0] sb_a_i = '0, sb_b_i = '0, sb_oe_a_i = '0, sb_oe_b_i = '0;
  logic [1:0] so_a_o, so_b_o;
  logic [2:0] sb_a_o, sb_b_o;
  logic mon_mr_i = 1'b1, mon_mx_i = 1'b1;
  logic mon_valid_o, mon_mr_o, mon_mx_o;

  int n_chk = 0, n_fail = 0, n_valid = 0;
  bit done = 0;

  logic [1:0] e_so_a = '0, e_so_b = '0;
  logic [2:0] e_sb_a = '0, e_sb_b = '0;
  logic       e_mr = 1'b1, e_mx = 1'b1;

  always #5ns clk_i = ~clk_i;

  cip_top u_cip_top (.*);

  always @(negedge clk_i) if (rst_ni && mon_valid_o) n_valid++;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] up_model(logic [1:0] sa, logic [2:0] ba, logic [2:0] oa,
                                          logic [1:0] sbv, logic [2:0] bb, logic [2:0] ob,
                                          logic mr, logic mx);
    return {sa[0], sa[1], oa[0] | ba[0], sbv[0], sbv[1], ob[0] | bb[0], mr, mx};
  endfunction

  // Runs one slot; nbits < 8 ends it early.
  task automatic do_slot(input logic [7:0] dn, input int nbits);
    logic [7:0] got, exp_up;
    bit en_ok;
    int v0;
    got = '1;
    en_ok = 1;
    v0 = n_valid;
    exp_up = up_model(si_a_i, sb_a_i, sb_oe_a_i, si_b_i, sb_b_i, sb_oe_b_i, mon_mr_i, mon_mx_i);
    @(negedge clk_i) slot_i = 1'b1;
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk_i);
      got[7-i] = up_bit_o;
      en_ok &= up_en_o;
      dn_bit_i = dn[7-i];
      bit_en_i = 1'b1;
      if (i == 2) begin  // R4: pins move after the snapshot
        si_a_i = 2'($urandom); si_b_i = 2'($urandom);
        sb_a_i = 3'($urandom); sb_b_i = 3'($urandom);
        mon_mr_i = 1'($urandom); mon_mx_i = 1'($urandom);
      end
      @(negedge clk_i) bit_en_i = 1'b0;
    end
    @(negedge clk_i);
    // R9: enable drops once eight bits are taken
    if (nbits == 8) chk(!up_en_o, "R9", "up_en after 8 bits", up_en_o, 0);
    slot_i = 1'b0;
    repeat (3) @(negedge clk_i);
    chk(en_ok, "R9", "up_en during slot", en_ok, 1);
    chk(!up_en_o && up_bit_o, "R2", "idle line", {up_en_o, up_bit_o}, 2'b01);
    if (nbits == 8) begin
      // R2 R3 R4
      chk(got == exp_up, "R2", "upstream octet", got, exp_up);
      if (!dn[7]) begin
        e_so_a = dn[6:5];
        e_sb_a = (e_sb_a & ~sb_oe_a_i) | (dn[4:2] & sb_oe_a_i);
      end else begin
        e_so_b = dn[6:5];
        e_sb_b = (e_sb_b & ~sb_oe_b_i) | (dn[4:2] & sb_oe_b_i);
      end
      e_mr = dn[1];
      e_mx = dn[0];
      chk(n_valid - v0 == 1, "R8", "strobe count", n_valid - v0, 1);
    end else begin
      chk(n_valid - v0 == 0, "R7", "strobe on short slot", n_valid - v0, 0);
    end
    chk({so_a_o, sb_a_o} == {e_so_a, e_sb_a}, "R5", "channel A latches",
        {so_a_o, sb_a_o}, {e_so_a, e_sb_a});
    chk({so_b_o, sb_b_o} == {e_so_b, e_sb_b}, "R6", "channel B latches",
        {so_b_o, sb_b_o}, {e_so_b, e_sb_b});
    chk({mon_mr_o, mon_mx_o} == {e_mr, e_mx}, "R8", "monitor bits",
        {mon_mr_o, mon_mx_o}, {e_mr, e_mx});
  endtask

  initial begin
    #2_000_000ns;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired: actual 1 expected 0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_c1a0));
    repeat (3) @(negedge clk_i);
    // R1 during reset
    chk({so_a_o, sb_a_o, so_b_o, sb_b_o} == '0, "R1", "latches in reset",
        {so_a_o, sb_a_o, so_b_o, sb_b_o}, 0);
    chk({mon_valid_o, mon_mr_o, mon_mx_o, up_en_o, up_bit_o} == 5'b01101, "R1",
        "control outputs in reset", {mon_valid_o, mon_mr_o, mon_mx_o, up_en_o, up_bit_o}, 5'b01101);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk({so_a_o, sb_a_o, so_b_o, sb_b_o} == '0 && up_bit_o, "R1", "state after reset",
        {so_a_o, sb_a_o, so_b_o, sb_b_o, up_bit_o}, 1);
    fsc_i = 1'b1; @(negedge clk_i) fsc_i = 1'b0;

    // R5 channel A, all SB outputs
    sb_oe_a_i = 3'b111; sb_oe_b_i = 3'b111;
    do_slot(8'b0_11_111_0_1, 8);
    // R5 channel B
    do_slot(8'b1_10_101_1_0, 8);
    // R6 SB as inputs: latches hold
    sb_oe_a_i = 3'b000;
    do_slot(8'b0_01_000_0_0, 8);
    sb_oe_a_i = 3'b010;
    do_slot(8'b0_00_000_1_1, 8);
    // R3 SB1 output-configured reads 1 with low pin; input passes pin
    sb_oe_a_i = 3'b001; sb_a_i = 3'b000; sb_oe_b_i = 3'b110; sb_b_i = 3'b110;
    si_a_i = 2'b01; si_b_i = 2'b10; mon_mr_i = 1'b0; mon_mx_i = 1'b1;
    do_slot(8'b1_01_010_0_0, 8);
    // R7 short slots
    do_slot(8'b0_10_111_1_1, 5);
    do_slot(8'b1_11_111_0_0, 7);

    for (int f = 0; f < 200; f++) begin
      sb_oe_a_i = 3'($urandom); sb_oe_b_i = 3'($urandom);
      si_a_i = 2'($urandom); si_b_i = 2'($urandom);
      sb_a_i = 3'($urandom); sb_b_i = 3'($urandom);
      mon_mr_i = 1'($urandom); mon_mx_i = 1'($urandom);
      if (($urandom % 8) == 0) do_slot(8'($urandom), 1 + int'($urandom % 7));
      else                     do_slot(8'($urandom), 8);
      if (($urandom % 4) == 0) begin
        fsc_i = 1'b1; @(negedge clk_i) fsc_i = 1'b0;
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule